// File: doc/BRIEF.md
# Prescaled General-Purpose Timer

A 16-bit up-counter behind a small register port, meant to give software a periodic tick or a one-off delay. A mode word sets four things: whether the timer runs, which tick source feeds it, an 8-bit divide applied to that source, and what happens when the count meets a programmed compare value. A meeting of the two latches a flag in an event register. The single interrupt line is high while that flag is set and the mode word enables it.

Software writes a compare value, optionally loads the counter, and then writes the mode word with the run bit set. The block produces either a fixed period (the counter returns to zero on a match) or a free-running count with a periodic flag (the counter carries on and wraps). Flags are acknowledged by writing ones to them. A fifth register is spare read/write storage.

Top module: `gpt_top`

## Requirements
- R1: After reset the mode, compare, spare, counter and event registers all read 0, and the interrupt output is low.
- R2: The counter changes only on a count tick, on a load, or on a stop clear. While mode bit 0 (run) is 0, no count tick occurs and the divider is held at its start.
- R3: A mode write that changes bit 0 from 1 to 0 sets the counter to 0 on the same clock edge.
- R4: With mode bits [15:8] = P, one count tick occurs on every (P+1)-th source tick. The first count tick comes on the (P+1)-th source tick after run goes to 1.
- R5: Mode bits [2:1] choose the source. 00 and 11 give no source ticks. 01 gives one tick per clock. 10 gives one tick per clock cycle in which ext_tick is high.
- R6: On a count tick that finds the counter equal to the compare value, the counter becomes 0 when mode bit 3 is 1. When mode bit 3 is 0 it increments, and all ones wraps to 0.
- R7: The count tick that finds the counter equal to the compare value sets event bit 1. Event bit 0 and bits [15:2] always read 0.
- R8: irq is high exactly when mode bit 4 and event bit 1 are both 1.
- R9: Writing the event register clears bit 1 when the written bit 1 is 1 and leaves it unchanged otherwise. A match on the same edge wins, and the bit stays set.
- R10: A counter write loads the written value on that edge. It takes priority over counting and over the stop clear.
- R11: The spare register reads back the last value written to it.
- R12: Address 0 is mode, 1 compare, 2 spare, 3 counter and 4 event. rd_data follows addr combinationally. Addresses 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 3 | Register select |
| wr_data | input | 16 | Write data |
| ext_tick | input | 1 | External source qualifier, sampled each clock |
| rd_data | output | 16 | Read data for addr |
| irq | output | 1 | Interrupt request |

## Verification
Every register reacts on the clock edge that samples the write or tick. rd_data and irq are combinational from the registers, so a result is due one edge after its stimulus. The one exception is the divider: the first count tick lands P+1 source edges after the run write. The bench drives inputs on the falling edge and updates its model on the rising edge. It compares rd_data and irq on the next falling edge. Hand-timed peeks after counted edges cover the divide, wrap, restart and set-versus-clear cases.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    // register addresses (decoded by the register file)
    localparam int unsigned ADR_MODE = 0;
    localparam int unsigned ADR_CMP  = 1;
    localparam int unsigned ADR_SPARE = 2;
    localparam int unsigned ADR_CNT  = 3;
    localparam int unsigned ADR_EVT  = 4;

    // mode word bit positions
    localparam int unsigned MB_RUN     = 0;
    localparam int unsigned MB_SRC_LO  = 1;
    localparam int unsigned MB_RESTART = 3;
    localparam int unsigned MB_IEN     = 4;

    // event word bit position
    localparam int unsigned EB_MATCH = 1;

    typedef enum logic [1:0] {
        SRC_OFF = 2'b00,
        SRC_SYS = 2'b01,
        SRC_EXT = 2'b10,
        SRC_RSV = 2'b11
    } src_e;

endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale
    import gpt_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  src_e             src_sel,
    input  logic             ext_tick,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       src_en;

    always_comb begin
        st_d   = st_q;
        src_en = 1'b0;
        unique case (src_sel)
            SRC_SYS: src_en = 1'b1;
            SRC_EXT: src_en = ext_tick;
            default: src_en = 1'b0;
        endcase
        tick = run && src_en && (st_q.pre == div);
        if (!run) begin
            st_d.pre = '0;
        end else if (src_en) begin
            st_d.pre = (st_q.pre == div) ? '0 : st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0)); // R4

    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || src_sel == SRC_OFF || src_sel == SRC_RSV) |-> !tick); // R5

endmodule

// File: rtl/gpt_count.sv
module gpt_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             stop_clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             evt_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             match_evt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             evt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        hit  = tick && (st_q.cnt == cmp_val);
        if (load) begin
            st_d.cnt = load_val;
        end else if (stop_clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = (hit && restart) ? '0 : st_q.cnt + 1'b1;
        end
        if (hit)          st_d.evt = 1'b1;
        else if (evt_clr) st_d.evt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt       = st_q.cnt;
    assign match_evt = st_q.evt;

    AST_EVT_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == cmp_val) |=> match_evt); // R7

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == cmp_val && restart && !load && !stop_clr) |=> cnt == '0); // R6

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val)); // R10

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && !(tick && cnt == cmp_val)) |=> !match_evt); // R9

endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
    import gpt_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              match_evt,
    output logic [CNT_W-1:0]  mode,
    output logic [CNT_W-1:0]  cmp_val,
    output logic [CNT_W-1:0]  rd_data,
    output logic              stop_clr,
    output logic              cnt_load,
    output logic              evt_clr
);

    typedef struct packed {
        logic [CNT_W-1:0] mode;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] spare;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       sel_mode, sel_cmp, sel_spare, sel_cnt, sel_evt;

    always_comb begin
        sel_mode  = (addr == ADDR_W'(ADR_MODE));
        sel_cmp   = (addr == ADDR_W'(ADR_CMP));
        sel_spare = (addr == ADDR_W'(ADR_SPARE));
        sel_cnt   = (addr == ADDR_W'(ADR_CNT));
        sel_evt   = (addr == ADDR_W'(ADR_EVT));

        st_d = st_q;
        if (wr_en && sel_mode)  st_d.mode  = wr_data;
        if (wr_en && sel_cmp)   st_d.cmp   = wr_data;
        if (wr_en && sel_spare) st_d.spare = wr_data;

        stop_clr = wr_en && sel_mode && st_q.mode[MB_RUN] && !wr_data[MB_RUN];
        cnt_load = wr_en && sel_cnt;
        evt_clr  = wr_en && sel_evt && wr_data[EB_MATCH];

        rd_data = '0;
        if (sel_mode)  rd_data = st_q.mode;
        if (sel_cmp)   rd_data = st_q.cmp;
        if (sel_spare) rd_data = st_q.spare;
        if (sel_cnt)   rd_data = cnt_val;
        if (sel_evt)   rd_data[EB_MATCH] = match_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode    = st_q.mode;
    assign cmp_val = st_q.cmp;

    AST_UNMAPPED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > ADDR_W'(ADR_EVT)) |=> ($stable(mode) && $stable(cmp_val))); // R12

    AST_SPARE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(ADR_SPARE)) |=> (st_q.spare == $past(wr_data))); // R11

endmodule

// File: rtl/gpt_top.sv
module gpt_top
    import gpt_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              ext_tick,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);

    localparam int unsigned DIV_LO = CNT_W - DIV_W;

    logic [CNT_W-1:0] mode, cmp_val, cnt;
    logic             stop_clr, cnt_load, evt_clr, tick, match_evt;
    src_e             src_sel;

    assign src_sel = src_e'(mode[MB_SRC_LO +: 2]);

    gpt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .cnt_val   (cnt),
        .match_evt (match_evt),
        .mode      (mode),
        .cmp_val   (cmp_val),
        .rd_data   (rd_data),
        .stop_clr  (stop_clr),
        .cnt_load  (cnt_load),
        .evt_clr   (evt_clr)
    );

    gpt_prescale #(.DIV_W(DIV_W)) i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (mode[MB_RUN]),
        .src_sel  (src_sel),
        .ext_tick (ext_tick),
        .div      (mode[DIV_LO +: DIV_W]),
        .tick     (tick)
    );

    gpt_count #(.CNT_W(CNT_W)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .restart   (mode[MB_RESTART]),
        .cmp_val   (cmp_val),
        .stop_clr  (stop_clr),
        .load      (cnt_load),
        .load_val  (wr_data),
        .evt_clr   (evt_clr),
        .cnt       (cnt),
        .match_evt (match_evt)
    );

    assign irq = mode[MB_IEN] && match_evt;

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[MB_RUN] && !cnt_load && !stop_clr) |=> $stable(cnt)); // R2

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_clr && !cnt_load) |=> cnt == '0); // R3

endmodule

// File: tb/test_gpt_top.sv
module test_gpt_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic        ext_tick = 1'b0;
    logic [15:0] rd_data;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10ns clk = ~clk;

    gpt_top i_gpt_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .ext_tick(ext_tick), .rd_data(rd_data), .irq(irq)
    );

    // behavioural model
    logic [15:0] m_mode, m_cmp, m_spare, m_cnt;
    int          m_pre;
    logic        m_evt;

    always @(posedge clk or negedge rst_n) begin : model
        logic src_on, tk, hit, clr, n_evt;
        logic [15:0] n_cnt;
        int n_pre;
        if (!rst_n) begin
            m_mode = 0; m_cmp = 0; m_spare = 0; m_cnt = 0; m_pre = 0; m_evt = 0;
        end else begin
            src_on = (m_mode[2:1] == 2'b01) || (m_mode[2:1] == 2'b10 && ext_tick);
            tk = 0;
            n_pre = m_pre;
            if (!m_mode[0]) n_pre = 0;
            else if (src_on) begin
                if (m_pre == int'(m_mode[15:8])) begin tk = 1; n_pre = 0; end
                else n_pre = m_pre + 1;
            end
            hit = tk && (m_cnt == m_cmp);
            clr = wr_en && addr == 3'd0 && m_mode[0] && !wr_data[0];
            n_cnt = m_cnt;
            if (wr_en && addr == 3'd3) n_cnt = wr_data;
            else if (clr) n_cnt = 0;
            else if (tk) n_cnt = (hit && m_mode[3]) ? 16'd0 : m_cnt + 16'd1;
            n_evt = hit ? 1'b1 : ((wr_en && addr == 3'd4 && wr_data[1]) ? 1'b0 : m_evt);
            if (wr_en && addr == 3'd0) m_mode = wr_data;
            if (wr_en && addr == 3'd1) m_cmp = wr_data;
            if (wr_en && addr == 3'd2) m_spare = wr_data;
            m_cnt = n_cnt; m_pre = n_pre; m_evt = n_evt;
        end
    end

    function automatic logic [15:0] mread(input logic [2:0] a);
        case (a)
            3'd0: return m_mode;
            3'd1: return m_cmp;
            3'd2: return m_spare;
            3'd3: return m_cnt;
            3'd4: return {14'd0, m_evt, 1'b0};
            default: return 16'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // drive, let one edge pass, compare on the falling edge
    task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d,
                        input logic ext = 1'b0);
        string tag;
        wr_en = we; addr = a; wr_data = d; ext_tick = ext;
        @(negedge clk);
        case (a)
            3'd2: tag = "R11";
            3'd3: tag = "R4";
            3'd4: tag = "R7";
            default: tag = "R12";
        endcase
        chk(tag, rd_data, mread(a));
        chk("R8", {15'd0, irq}, {15'd0, m_mode[4] & m_evt});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd3, 16'd0);
    endtask

    task automatic peek(input string tag, input logic [2:0] a, input logic [15:0] exp);
        wr_en = 1'b0; addr = a;
        #1ns;
        chk(tag, rd_data, exp);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        for (int a = 0; a < 5; a++) peek("R1", 3'(a), 16'd0);
        chk("R1", {15'd0, irq}, 16'd0);

        // restart mode with interrupt, compare 5
        step(1, 3'd1, 16'd5);
        step(1, 3'd0, 16'h001B);
        idle(6);
        peek("R6", 3'd3, 16'd0);
        peek("R7", 3'd4, 16'd2);
        chk("R8", {15'd0, irq}, 16'd1);

        // stop clears, event write-one-clear
        step(1, 3'd0, 16'h0000);
        peek("R3", 3'd3, 16'd0);
        step(1, 3'd4, 16'hFFFF);
        peek("R9", 3'd4, 16'd0);
        chk("R8", {15'd0, irq}, 16'd0);

        // free-run with wrap
        step(1, 3'd3, 16'hFFFE);
        step(1, 3'd1, 16'd2);
        step(1, 3'd0, 16'h0003);
        idle(5);
        peek("R6", 3'd3, 16'd3);
        peek("R7", 3'd4, 16'd2);
        chk("R8", {15'd0, irq}, 16'd0);

        // divide by 4
        step(1, 3'd0, 16'h0000);
        step(1, 3'd1, 16'hFFFF);
        step(1, 3'd0, 16'h0303);
        idle(3);
        peek("R4", 3'd3, 16'd0);
        idle(1);
        peek("R4", 3'd3, 16'd1);
        idle(4);
        peek("R4", 3'd3, 16'd2);

        // external source, then reserved and off sources
        step(1, 3'd0, 16'h0000);
        step(1, 3'd0, 16'h0005);
        step(0, 3'd3, 0, 1); step(0, 3'd3, 0, 0); step(0, 3'd3, 0, 1);
        step(0, 3'd3, 0, 1); step(0, 3'd3, 0, 0);
        peek("R5", 3'd3, 16'd3);
        step(1, 3'd0, 16'h0007, 0);
        for (int i = 0; i < 4; i++) step(0, 3'd3, 0, 1);
        peek("R5", 3'd3, 16'd3);
        step(1, 3'd0, 16'h0001);
        idle(3);
        peek("R5", 3'd3, 16'd3);

        // stopped: clear, then load holds
        step(1, 3'd0, 16'h0002);
        peek("R3", 3'd3, 16'd0);
        step(1, 3'd3, 16'd7);
        idle(4);
        peek("R2", 3'd3, 16'd7);
        peek("R10", 3'd3, 16'd7);

        // match and clear on the same edge
        step(1, 3'd1, 16'd7);
        step(1, 3'd4, 16'h0002);
        peek("R9", 3'd4, 16'd0);
        step(1, 3'd0, 16'h000B);
        step(1, 3'd4, 16'h0002);
        peek("R9", 3'd4, 16'd2);
        peek("R6", 3'd3, 16'd0);
        step(1, 3'd4, 16'h0001);
        peek("R9", 3'd4, 16'd2);

        // load beats counting
        step(1, 3'd3, 16'h1234);
        peek("R10", 3'd3, 16'h1234);
        idle(1);
        peek("R10", 3'd3, 16'h1235);

        // spare and unmapped
        step(1, 3'd2, 16'hBEEF);
        peek("R11", 3'd2, 16'hBEEF);
        step(1, 3'd5, 16'hFFFF);
        peek("R12", 3'd5, 16'd0);
        peek("R12", 3'd7, 16'd0);
        peek("R12", 3'd0, 16'h000B);
        peek("R12", 3'd2, 16'hBEEF);

        // interrupt enable gating
        step(1, 3'd0, 16'h0000);
        chk("R8", {15'd0, irq}, 16'd0);
        step(1, 3'd0, 16'h0010);
        chk("R8", {15'd0, irq}, 16'd1);
        step(1, 3'd4, 16'h0002);
        chk("R8", {15'd0, irq}, 16'd0);

        // mixed traffic against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            logic [2:0] a;
            logic [15:0] d;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr[2:0];
            d = {lfsr[7:0], lfsr[15:8]};
            if (a == 3'd0) d = d & 16'h031F;
            if (a == 3'd1 || a == 3'd3) d = d & 16'h000F;
            step(lfsr[11] & lfsr[6], a, d, lfsr[9]);
        end

        finish_run();
    end

endmodule